// File: doc/BRIEF.md
# Dual Thermometer Mask Generator

This block turns two 6-bit control fields into two 32-bit thermometer masks for a shift and field-extract datapath. One mask follows a length field and the other follows a shift-amount field. The two are computed side by side, with identical logic and no interaction between them.

Every output bit position has its own hard-wired constant, equal to 31 minus the position. The bit is set when the unsigned input field is strictly greater than that constant. Each comparison is built as a chain of single-bit stages. The chain starts at the least significant bit and ends at the most significant one, so the top stage has the final say. Where the constant bit is 0, a stage reduces to an OR. Where it is 1, the stage reduces to an AND. Stages under a run of low constant 1s are tied to 0.

A parameter adds an output register stage, which has a synchronous active-high reset. Without it, the masks follow the inputs combinationally.

Top module: `dual_mask_gen`

## Requirements
- R1: Bit p (0 to 31) of `len_mask_o` is 1 exactly when the unsigned value of `len_i` is greater than 31 − p.
- R2: Bit p of `amt_mask_o` is 1 exactly when the unsigned value of `amt_i` is greater than 31 − p. It does not depend on `len_i`, and `len_mask_o` does not depend on `amt_i`.
- R3: An input field of 0 makes its whole mask 0.
- R4: An input field of 32 or more (up to 63) makes its whole mask all ones.
- R5: For an input k from 0 to 32, the mask has exactly k ones, at bit positions 32 − k through 31. No 0 lies above a 1.
- R6: Bit 31 of a mask is 1 for every nonzero input. Bit 0 is 1 only for inputs of 32 or more.
- R7: With `REGISTERED` = 0, both masks follow the inputs in the same cycle, without any clock edge.
- R8: With `REGISTERED` = 1, both masks change only at a rising clock edge. They then show the values for the inputs present just before that edge, and hold between edges.
- R9: With `REGISTERED` = 1, `rst` high at a rising edge clears both masks to 0. This takes priority over capturing the inputs.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock for the optional register stage |
| rst | input | 1 | Synchronous active-high reset |
| len_i | input | 6 | Length field, unsigned |
| amt_i | input | 6 | Shift-amount field, unsigned |
| len_mask_o | output | 32 | Mask derived from `len_i` |
| amt_mask_o | output | 32 | Mask derived from `amt_i` |

## Verification
Two pairs of functions can land in the same cycle:

- **The two lanes.** They evaluate together. The bench drives unrelated values on both fields in every vector, including sweeps where one field rises while the other falls. Each mask is judged against its own reference, so any leak between the lanes shows up as a mismatch.
- **Reset and capture.** In the registered variant these meet at one clock edge. The bench holds all-ones-producing inputs while reset is high, and expects zeros after that edge. This shows that reset wins over capture.

// File: rtl/dm_pkg.sv
package dm_pkg;

   localparam int unsigned DM_FIELD_W_DEF = 6;
   localparam int unsigned DM_MASK_W_DEF  = 32;

   // Constant compared against at a given output position.
   function automatic int unsigned slice_const(input int unsigned pos,
                                               input int unsigned mask_w);
      return mask_w - 1 - pos;
   endfunction

   // Number of consecutive 1 bits at the bottom of a constant, capped at width.
   function automatic int unsigned trailing_ones(input int unsigned value,
                                                 input int unsigned width);
      int unsigned cnt;
      bit          run;
      cnt = 0;
      run = 1'b1;
      for (int unsigned b = 0; b < width; b++) begin
         if (run && value[b]) cnt++;
         else run = 1'b0;
      end
      return cnt;
   endfunction

endpackage

// File: rtl/dm_gt_chain.sv
// One position's comparator: gt_o = (k_i > CONST), evaluated as a chain
// whose final stage is the most significant bit.
module dm_gt_chain #(
   parameter int unsigned FIELD_W = dm_pkg::DM_FIELD_W_DEF,
   parameter int unsigned CONST   = 0
) (
   input  logic [FIELD_W-1:0] k_i,
   output logic               gt_o
);

   localparam int unsigned TAIL = dm_pkg::trailing_ones(CONST, FIELD_W);
   localparam logic [FIELD_W-1:0] CBITS = FIELD_W'(CONST);

   if (CONST >= (1 << FIELD_W)) begin : g_bad_const
      $error("dm_gt_chain: CONST does not fit in FIELD_W bits");
   end

   logic [FIELD_W-1:0] stage;

   for (genvar n = 0; n < FIELD_W; n++) begin : g_stage
      if (n < TAIL) begin : g_tied
         // Below a run of low constant 1s the chain can never be true.
         assign stage[n] = 1'b0;
      end else if (n == 0) begin : g_base
         // Constant bit 0 is 0 here, so the base reduces to the input bit.
         assign stage[n] = k_i[n];
      end else if (CBITS[n] == 1'b0) begin : g_or
         assign stage[n] = k_i[n] | stage[n-1];
      end else begin : g_and
         assign stage[n] = k_i[n] & stage[n-1];
      end
   end

   // Input bits feeding tied stages are intentionally dropped.
   logic tail_unused;
   assign tail_unused = ^k_i;

   assign gt_o = stage[FIELD_W-1];

endmodule

// File: rtl/dm_mask_lane.sv
// One full mask: a comparator chain for each output position.
module dm_mask_lane #(
   parameter int unsigned FIELD_W = dm_pkg::DM_FIELD_W_DEF,
   parameter int unsigned MASK_W  = dm_pkg::DM_MASK_W_DEF
) (
   input  logic [FIELD_W-1:0] field_i,
   output logic [MASK_W-1:0]  mask_o
);

   for (genvar p = 0; p < MASK_W; p++) begin : g_pos
      dm_gt_chain #(
         .FIELD_W (FIELD_W),
         .CONST   (dm_pkg::slice_const(p, MASK_W))
      ) u_cmp (
         .k_i  (field_i),
         .gt_o (mask_o[p])
      );
   end

endmodule

// File: rtl/dm_out_stage.sv
// Optional output register; passes the mask straight through when disabled.
module dm_out_stage #(
   parameter int unsigned MASK_W     = dm_pkg::DM_MASK_W_DEF,
   parameter bit          REGISTERED = 1'b0
) (
   input  logic              clk,
   input  logic              rst,
   input  logic [MASK_W-1:0] d_i,
   output logic [MASK_W-1:0] q_o
);

   if (REGISTERED) begin : g_reg
      always_ff @(posedge clk) begin
         if (rst) q_o <= '0;
         else     q_o <= d_i;
      end
   end else begin : g_wire
      logic ctl_unused;
      assign ctl_unused = clk ^ rst;
      assign q_o = d_i;
   end

endmodule

// File: rtl/dual_mask_gen.sv
module dual_mask_gen #(
   parameter int unsigned FIELD_W    = dm_pkg::DM_FIELD_W_DEF,
   parameter int unsigned MASK_W     = dm_pkg::DM_MASK_W_DEF,
   parameter bit          REGISTERED = 1'b0
) (
   input  logic               clk,
   input  logic               rst,
   input  logic [FIELD_W-1:0] len_i,
   input  logic [FIELD_W-1:0] amt_i,
   output logic [MASK_W-1:0]  len_mask_o,
   output logic [MASK_W-1:0]  amt_mask_o
);

   if (MASK_W < 2) begin : g_bad_mask
      $error("dual_mask_gen: MASK_W must be at least 2");
   end
   if (MASK_W > (1 << FIELD_W)) begin : g_bad_field
      $error("dual_mask_gen: FIELD_W too narrow for MASK_W position constants");
   end

   localparam logic [MASK_W-1:0] ALL_ONES = '1;
   localparam logic [FIELD_W:0]  SAT_K    = (FIELD_W+1)'(MASK_W);

   logic [MASK_W-1:0] len_cmb, amt_cmb;

   dm_mask_lane #(.FIELD_W(FIELD_W), .MASK_W(MASK_W)) u_len_lane (
      .field_i (len_i),
      .mask_o  (len_cmb)
   );

   dm_mask_lane #(.FIELD_W(FIELD_W), .MASK_W(MASK_W)) u_amt_lane (
      .field_i (amt_i),
      .mask_o  (amt_cmb)
   );

   dm_out_stage #(.MASK_W(MASK_W), .REGISTERED(REGISTERED)) u_len_out (
      .clk (clk), .rst (rst), .d_i (len_cmb), .q_o (len_mask_o)
   );

   dm_out_stage #(.MASK_W(MASK_W), .REGISTERED(REGISTERED)) u_amt_out (
      .clk (clk), .rst (rst), .d_i (amt_cmb), .q_o (amt_mask_o)
   );

   // Checks on the combinational lane results.
   a_r3_len_zero: assert property (@(posedge clk) disable iff (rst)
      (len_i == '0) |-> (len_cmb == '0));
   a_r3_amt_zero: assert property (@(posedge clk) disable iff (rst)
      (amt_i == '0) |-> (amt_cmb == '0));
   a_r4_len_sat: assert property (@(posedge clk) disable iff (rst)
      ({1'b0, len_i} >= SAT_K) |-> (len_cmb == ALL_ONES));
   a_r4_amt_sat: assert property (@(posedge clk) disable iff (rst)
      ({1'b0, amt_i} >= SAT_K) |-> (amt_cmb == ALL_ONES));
   a_r5_len_thermo: assert property (@(posedge clk) disable iff (rst)
      $onehot0(~len_cmb + MASK_W'(1)));
   a_r5_amt_thermo: assert property (@(posedge clk) disable iff (rst)
      $onehot0(~amt_cmb + MASK_W'(1)));
   a_r5_len_count: assert property (@(posedge clk) disable iff (rst)
      ({1'b0, len_i} <= SAT_K) |-> ($countones(len_cmb) == int'(len_i)));
   a_r5_amt_count: assert property (@(posedge clk) disable iff (rst)
      ({1'b0, amt_i} <= SAT_K) |-> ($countones(amt_cmb) == int'(amt_i)));
   a_r6_len_top: assert property (@(posedge clk) disable iff (rst)
      (len_i != '0) |-> len_cmb[MASK_W-1]);

   if (REGISTERED) begin : g_reg_checks
      a_r9_len_clear: assert property (@(posedge clk)
         rst |=> (len_mask_o == '0));
      a_r9_amt_clear: assert property (@(posedge clk)
         rst |=> (amt_mask_o == '0));
      a_r8_len_lag: assert property (@(posedge clk) disable iff (rst)
         ({1'b0, len_i} >= SAT_K) |=> (len_mask_o == ALL_ONES));
      a_r8_amt_lag: assert property (@(posedge clk) disable iff (rst)
         (amt_i == '0) |=> (amt_mask_o == '0));
   end else begin : g_comb_checks
      a_r7_len_now: assert property (@(posedge clk) disable iff (rst)
         (len_i == '0) |-> (len_mask_o == '0));
      a_r7_amt_now: assert property (@(posedge clk) disable iff (rst)
         ({1'b0, amt_i} >= SAT_K) |-> (amt_mask_o == ALL_ONES));
   end

endmodule

// File: tb/test_dual_mask_gen.sv
module test_dual_mask_gen;

   logic       clk = 1'b0;
   logic       rst = 1'b1;
   logic [5:0] len = 6'd40;
   logic [5:0] amt = 6'd50;
   logic [31:0] c_len, c_amt, r_len, r_amt;
   int unsigned n_run = 0, n_fail = 0;
   bit done = 1'b0;

   always #5 clk = ~clk;

   dual_mask_gen #(.REGISTERED(1'b0)) i_dual_mask_gen (
      .clk(clk), .rst(rst), .len_i(len), .amt_i(amt),
      .len_mask_o(c_len), .amt_mask_o(c_amt));

   dual_mask_gen #(.REGISTERED(1'b1)) i_dual_mask_gen_reg (
      .clk(clk), .rst(rst), .len_i(len), .amt_i(amt),
      .len_mask_o(r_len), .amt_mask_o(r_amt));

   // Stimulus table: {len, amt}.
   localparam int NV = 16;
   localparam logic [11:0] VEC [NV] = '{
      {6'd0,  6'd63}, {6'd1,  6'd32}, {6'd31, 6'd33}, {6'd32, 6'd0},
      {6'd33, 6'd1},  {6'd7,  6'd24}, {6'd16, 6'd16}, {6'd24, 6'd8},
      {6'd63, 6'd31}, {6'd15, 6'd17}, {6'd2,  6'd30}, {6'd30, 6'd2},
      {6'd47, 6'd5},  {6'd8,  6'd9},  {6'd4,  6'd48}, {6'd12, 6'd0}
   };

   function automatic logic [31:0] ref_mask(input logic [5:0] k);
      logic [31:0] m;
      for (int p = 0; p < 32; p++) m[p] = (int'(k) > 31 - p);
      return m;
   endfunction

   task automatic chk(input string req, input logic [31:0] act,
                      input logic [31:0] exp);
      n_run++;
      if (act !== exp) begin
         n_fail++;
         $display("FAIL %s: got %h expected %h", req, act, exp);
      end
   endtask

   task automatic drive(input logic [5:0] l, input logic [5:0] a);
      @(negedge clk);
      len = l;
      amt = a;
      #1;
   endtask

   initial begin
      // Reset state with saturating inputs: reset beats capture (R9).
      repeat (2) @(posedge clk);
      @(negedge clk);
      chk("R9 reset len", r_len, 32'h0);
      chk("R9 reset amt", r_amt, 32'h0);
      chk("R7 comb during reset len", c_len, 32'hFFFF_FFFF);
      chk("R4 comb amt 50", c_amt, 32'hFFFF_FFFF);
      rst = 1'b0;

      // Table walk: combinational now, registered after one edge.
      for (int v = 0; v < NV; v++) begin
         drive(VEC[v][11:6], VEC[v][5:0]);
         chk("R1 table len", c_len, ref_mask(VEC[v][11:6]));
         chk("R2 table amt", c_amt, ref_mask(VEC[v][5:0]));
         @(negedge clk);
         chk("R8 table reg len", r_len, ref_mask(VEC[v][11:6]));
         chk("R8 table reg amt", r_amt, ref_mask(VEC[v][5:0]));
      end

      // Exhaustive sweep, fields moving in opposite directions.
      for (int k = 0; k < 64; k++) begin
         drive(6'(k), 6'(63 - k));
         chk("R1 sweep len", c_len, ref_mask(6'(k)));
         chk("R2 sweep amt", c_amt, ref_mask(6'(63 - k)));
         if (k <= 32) begin
            n_run++;
            if ($countones(c_len) != k) begin
               n_fail++;
               $display("FAIL R5 count: got %0d expected %0d",
                        $countones(c_len), k);
            end
         end
      end

      // Named corner cases.
      drive(6'd0, 6'd32);
      chk("R3 zero len", c_len, 32'h0);
      chk("R4 amt 32", c_amt, 32'hFFFF_FFFF);
      drive(6'd1, 6'd31);
      chk("R6 top bit only", c_len, 32'h8000_0000);
      chk("R6 bit0 clear at 31", c_amt, 32'hFFFF_FFFE);
      drive(6'd5, 6'd63);
      chk("R5 five ones", c_len, 32'hF800_0000);
      chk("R4 amt 63", c_amt, 32'hFFFF_FFFF);

      // Hold between edges (R8).
      @(negedge clk);
      chk("R8 captured len 5", r_len, 32'hF800_0000);
      len = 6'd20;
      #2;
      chk("R8 hold before edge", r_len, 32'hF800_0000);
      chk("R7 comb follows now", c_len, ref_mask(6'd20));
      @(negedge clk);
      chk("R8 updated after edge", r_len, ref_mask(6'd20));

      // Reset overrides capture mid-run (R9).
      @(negedge clk);
      rst = 1'b1;
      len = 6'd63;
      amt = 6'd40;
      @(negedge clk);
      chk("R9 clear len", r_len, 32'h0);
      chk("R9 clear amt", r_amt, 32'h0);
      rst = 1'b0;
      @(negedge clk);
      chk("R8 after reset len", r_len, 32'hFFFF_FFFF);

      done = 1'b1;
      $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
   end

   initial begin
      repeat (200000) @(posedge clk);
      if (!done) begin
         n_run++;
         n_fail++;
         $display("FAIL watchdog: got timeout expected completion");
         $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
         $finish;
      end
   end

endmodule